// File: doc/BRIEF.md
# Grouped Event Interrupt Aggregator

This block gathers event lines from a serial-link controller core and turns them into a small set of interrupt pulses, one for each functional group. Some lines are levels that stay high while a condition lasts. Others are single-cycle pulses. The inputs are held in three 32-bit banks. Software reaches the banks through a plain register bus, with one write strobe, a word address, write data and a read path with no wait states. Each bank has a write-one-to-set enable register, a write-one-to-clear enable register and a status view. The bank that receives pulses also has a write-one-to-clear status register, because those events must be latched until software handles them.

A level-sourced group fires once, on the rising edge of the OR of its enabled sources. After software has serviced the group, it writes the group's vector number to the end-of-interrupt register. If any enabled source of that group is still high at that moment, the group fires again. This means a level that never dropped cannot be lost. A pulse-sourced group fires when one of its enabled sticky status bits sets anew. A bit that is already set does not fire it again.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every enable register and every status view reads 0, and all nine `irq_o` bits are 0.
- R2: Writing 1 to a bit of an enable-set register sets that enable bit, and writing 1 to the same bit of the enable-clear register clears it. Writing 0 changes nothing. Both addresses read back the current mask, and reserved bits read 0 (bank 0 uses bits 5:0, bank 1 bits 26:0, bank 2 bits 11:0).
- R3: The status view of bank 0 or bank 1 returns the live source level ANDed with that bank's enable mask.
- R4: A level group's `irq_o` bit is high for exactly one cycle, in the cycle after the clock edge at which the OR of its enabled sources first goes high. It does not fire again while that OR stays high.
- R5: Writing the value v (0 to 3) to the end-of-interrupt address makes `irq_o[v]` high for one cycle in the next cycle, provided the OR of that group's enabled sources is high at the write. If that OR is low, the write has no effect.
- R6: An end-of-interrupt write with any value outside 0 to 3 produces no pulse.
- R7: A one-cycle source pulse on bank 2 sets a sticky status bit, whether or not the bit is enabled. The bank 2 status view returns the raw sticky bits. Writing 1 to a bit of the status-clear register clears that bit, and writing 0 leaves it unchanged.
- R8: If a source pulse and a status-clear write hit the same bank 2 bit in the same cycle, the bit ends up set.
- R9: A pulse group's `irq_o` bit is high for one cycle after an enabled bank 2 bit goes from clear to set. It stays low when the bit was already set, or when the bit is disabled.
- R10: The address map is: 0/1/2 = bank 0 enable-set, enable-clear and status; 3/4/5 = the same for bank 1; 6/7/8 = the same for bank 2; 9 = bank 2 status-clear; 10 = end-of-interrupt vector. Any other address reads 0. The `irq_o` bits map as follows:
  - 0 = bank 0 bits 5:0
  - 1 = bank 1 bits 21:0
  - 2 = bank 1 bits 25:22
  - 3 = bank 1 bit 26
  - 4 = bank 2 bits 5:0
  - 5 = bank 2 bits 8:6
  - 6 = bank 2 bit 9
  - 7 = bank 2 bit 10
  - 8 = bank 2 bit 11

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_a_i | input | 6 | Bank 0 level sources |
| lvl_b_i | input | 27 | Bank 1 level sources |
| pls_c_i | input | 12 | Bank 2 one-cycle pulse sources |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| irq_o | output | 9 | One-cycle group interrupt pulses |

## Verification
The bench drives several stimulus patterns and checks each one against a reference model on every clock:
- A single level rising into an enabled group shows whether edge detection works.
- A second source of the same group rising while the first is still high separates true OR-edge detection from per-bit edges.
- End-of-interrupt writes made while the group's OR is high, and again after it has fallen, separate a real retrigger from an unconditional one. An out-of-range vector shows that the decode rejects it.
- Bank 2 pulses arriving on a bit that is clear, on a bit that is already set, on a disabled bit, and together with a clear write separate the new-set detection, the enable gating and the set-over-clear priority.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DW       = 32;
  localparam int ADDR_W   = 4;
  localparam int A_W      = 6;
  localparam int B_W      = 27;
  localparam int C_W      = 12;
  localparam int A_GROUPS = 1;
  localparam int B_GROUPS = 3;
  localparam int C_GROUPS = 5;
  localparam int N_IRQ    = A_GROUPS + B_GROUPS + C_GROUPS;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENSET = 4'd0, RA_ENCLR = 4'd1, RA_STAT = 4'd2,
    RB_ENSET = 4'd3, RB_ENCLR = 4'd4, RB_STAT = 4'd5,
    RC_ENSET = 4'd6, RC_ENCLR = 4'd7, RC_STAT = 4'd8,
    RC_STCLR = 4'd9, R_EOI    = 4'd10
  } reg_addr_e;

  // contiguous bit mask from lo to hi inclusive
  function automatic logic [DW-1:0] span(input int lo, input int hi);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  // true when a group holds at least one active bit
  function automatic logic hit_group(input logic [DW-1:0] bits, input logic [DW-1:0] mask);
    return |(bits & mask);
  endfunction
endpackage

// File: rtl/irqagg_level_bank.sv
module irqagg_level_bank
  import irqagg_pkg::*;
#(
  parameter int W        = 6,
  parameter int NG       = 1,
  parameter int VEC_BASE = 0,
  parameter logic [NG-1:0][DW-1:0] GMASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  src,
  input  logic          en_set_we,
  input  logic          en_clr_we,
  input  logic [W-1:0]  wdata,
  input  logic          eoi_we,
  input  logic [DW-1:0] eoi_vec,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  status_o,
  output logic [NG-1:0] irq_o
);
  logic [W-1:0]  en_q;
  logic [NG-1:0] any_w, any_q, eoi_hit_w, irq_q;

  assign status_o = src & en_q;
  assign en_o     = en_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (en_set_we) en_q <= en_q | wdata;
    else if (en_clr_we) en_q <= en_q & ~wdata;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign any_w[g]     = hit_group(DW'(status_o), GMASK[g]);
    assign eoi_hit_w[g] = eoi_we && (eoi_vec == DW'(VEC_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        any_q[g] <= 1'b0;
        irq_q[g] <= 1'b0;
      end else begin
        any_q[g] <= any_w[g];
        irq_q[g] <= any_w[g] && (!any_q[g] || eoi_hit_w[g]);
      end
    end

    // R4
    rise_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_w[g]) |=> irq_q[g]);
    // R5
    pulse_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[g] |-> $past(any_w[g]));
  end
endmodule

// File: rtl/irqagg_pulse_bank.sv
module irqagg_pulse_bank
  import irqagg_pkg::*;
#(
  parameter int W  = 12,
  parameter int NG = 5,
  parameter logic [NG-1:0][DW-1:0] GMASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  src,
  input  logic          en_set_we,
  input  logic          en_clr_we,
  input  logic          st_clr_we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  status_o,
  output logic [NG-1:0] irq_o
);
  logic [W-1:0]  en_q, st_q, clr_w, fresh_w;
  logic [NG-1:0] irq_q;

  assign clr_w    = st_clr_we ? wdata : '0;
  assign fresh_w  = src & ~st_q & en_q;
  assign en_o     = en_q;
  assign status_o = st_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_set_we)      en_q <= en_q | wdata;
      else if (en_clr_we) en_q <= en_q & ~wdata;
      st_q <= (st_q & ~clr_w) | src;
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= hit_group(DW'(fresh_w), GMASK[g]);
    end

    // R9
    pulse_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[g] |-> hit_group(DW'($past(en_q)), GMASK[g]));
  end

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(st_q) & ~$past(clr_w) & ~st_q) == '0));
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> (($past(src) & ~st_q) == '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [A_W-1:0]    lvl_a_i,
  input  logic [B_W-1:0]    lvl_b_i,
  input  logic [C_W-1:0]    pls_c_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_IRQ-1:0]  irq_o
);
  localparam logic [A_GROUPS-1:0][DW-1:0] MASK_A = {span(0, A_W-1)};
  localparam logic [B_GROUPS-1:0][DW-1:0] MASK_B = {span(26, 26), span(22, 25), span(0, 21)};
  localparam logic [C_GROUPS-1:0][DW-1:0] MASK_C =
    {span(11, 11), span(10, 10), span(9, 9), span(6, 8), span(0, 5)};

  logic [A_W-1:0] en_a, st_a;
  logic [B_W-1:0] en_b, st_b;
  logic [C_W-1:0] en_c, st_c;
  logic [A_GROUPS-1:0] irq_a;
  logic [B_GROUPS-1:0] irq_b;
  logic [C_GROUPS-1:0] irq_c;
  logic eoi_we;

  function automatic logic wr_to(input logic we, input logic [ADDR_W-1:0] a, input reg_addr_e r);
    return we && (a == r);
  endfunction

  assign eoi_we = wr_to(bus_we, bus_addr, R_EOI);

  irqagg_level_bank #(.W(A_W), .NG(A_GROUPS), .VEC_BASE(0), .GMASK(MASK_A)) u_bank_a (
    .clk, .rst_n, .src(lvl_a_i),
    .en_set_we(wr_to(bus_we, bus_addr, RA_ENSET)),
    .en_clr_we(wr_to(bus_we, bus_addr, RA_ENCLR)),
    .wdata(bus_wdata[A_W-1:0]), .eoi_we, .eoi_vec(bus_wdata),
    .en_o(en_a), .status_o(st_a), .irq_o(irq_a));

  irqagg_level_bank #(.W(B_W), .NG(B_GROUPS), .VEC_BASE(A_GROUPS), .GMASK(MASK_B)) u_bank_b (
    .clk, .rst_n, .src(lvl_b_i),
    .en_set_we(wr_to(bus_we, bus_addr, RB_ENSET)),
    .en_clr_we(wr_to(bus_we, bus_addr, RB_ENCLR)),
    .wdata(bus_wdata[B_W-1:0]), .eoi_we, .eoi_vec(bus_wdata),
    .en_o(en_b), .status_o(st_b), .irq_o(irq_b));

  irqagg_pulse_bank #(.W(C_W), .NG(C_GROUPS), .GMASK(MASK_C)) u_bank_c (
    .clk, .rst_n, .src(pls_c_i),
    .en_set_we(wr_to(bus_we, bus_addr, RC_ENSET)),
    .en_clr_we(wr_to(bus_we, bus_addr, RC_ENCLR)),
    .st_clr_we(wr_to(bus_we, bus_addr, RC_STCLR)),
    .wdata(bus_wdata[C_W-1:0]),
    .en_o(en_c), .status_o(st_c), .irq_o(irq_c));

  assign irq_o = {irq_c, irq_b, irq_a};

  always_comb begin
    case (bus_addr)
      RA_ENSET, RA_ENCLR: bus_rdata = DW'(en_a);
      RA_STAT:            bus_rdata = DW'(st_a);
      RB_ENSET, RB_ENCLR: bus_rdata = DW'(en_b);
      RB_STAT:            bus_rdata = DW'(st_b);
      RC_ENSET, RC_ENCLR: bus_rdata = DW'(en_c);
      RC_STAT:            bus_rdata = DW'(st_c);
      default:            bus_rdata = '0;
    endcase
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr inside {RC_ENSET, RC_ENCLR, RC_STAT}) |-> (bus_rdata[DW-1:C_W] == '0));
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  lvl_a = '0;
  logic [26:0] lvl_b = '0;
  logic [11:0] pls_c = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [8:0]  irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_aggregator uut (.clk, .rst_n, .lvl_a_i(lvl_a), .lvl_b_i(lvl_b), .pls_c_i(pls_c),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  // reference model
  logic [31:0] m_en [3];
  logic [31:0] m_st;
  bit m_prev [4];
  logic [8:0] m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_en[i]) m_en[i] = 0;
      m_st = 0; m_irq = 0;
      foreach (m_prev[i]) m_prev[i] = 0;
    end else begin
      bit cur [4];
      logic [31:0] la, lb, fr;
      la = {26'b0, lvl_a} & m_en[0];
      lb = {5'b0, lvl_b} & m_en[1];
      cur[0] = la != 0;
      cur[1] = lb[21:0] != 0;
      cur[2] = lb[25:22] != 0;
      cur[3] = lb[26];
      for (int g = 0; g < 4; g++) begin
        m_irq[g] = cur[g] && (!m_prev[g] || (we && addr == 10 && wdata == g));
        m_prev[g] = cur[g];
      end
      fr = {20'b0, pls_c} & ~m_st & m_en[2];
      m_irq[4] = fr[5:0] != 0;
      m_irq[5] = fr[8:6] != 0;
      m_irq[6] = fr[9];
      m_irq[7] = fr[10];
      m_irq[8] = fr[11];
      if (we && addr == 9) m_st = m_st & ~wdata;
      m_st = m_st | {20'b0, pls_c};
      for (int b = 0; b < 3; b++) begin
        logic [31:0] keep;
        keep = (b == 0) ? 32'h3f : (b == 1) ? 32'h7ff_ffff : 32'hfff;
        if (we && addr == 3*b)     m_en[b] = (m_en[b] | wdata) & keep;
        if (we && addr == 3*b + 1) m_en[b] = m_en[b] & ~wdata;
      end
    end
  end

  function automatic logic [31:0] mread(input logic [3:0] a);
    case (a)
      0, 1: return m_en[0];
      2:    return {26'b0, lvl_a} & m_en[0];
      3, 4: return m_en[1];
      5:    return {5'b0, lvl_b} & m_en[1];
      6, 7: return m_en[2];
      8:    return m_st;
      default: return 0;
    endcase
  endfunction

  // per-clock comparison of the interrupt outputs (R4 R5 R6 R9 R10)
  always @(negedge clk) if (rst_n && !done) begin
    total++;
    if (irq !== m_irq) begin
      bad++;
      $display("FAIL R4 R5 R6 R9 R10 irq_o at %0t: got %b exp %b", $time, irq, m_irq);
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] lit, input string tag);
    addr = a; #1;
    chk(rdata, mread(a), tag);
    chk(rdata, lit, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_c(input logic [11:0] b, input bit with_clr);
    @(negedge clk); pls_c = b;
    if (with_clr) begin we = 1; addr = 9; wdata = {20'b0, b}; end
    @(negedge clk); pls_c = 0; we = 0; wdata = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 11; a++) rd(a[3:0], 0, "R1 reset read");
    chk({23'b0, irq}, 0, "R1 irq after reset");

    // R2 enable set/clear, reserved bits
    wr(0, 32'hffff_ffff); idle(1); rd(0, 32'h3f, "R2 set reserved");
    wr(1, 32'h2);         idle(1); rd(1, 32'h3d, "R2 clear bit");
    wr(1, 32'h0);         idle(1); rd(0, 32'h3d, "R2 write zero");
    wr(0, 32'h0);         idle(1); rd(0, 32'h3d, "R2 set zero");

    // R3 R4 level edge detection on bank 0
    @(negedge clk); lvl_a = 6'h02; idle(3);
    rd(2, 32'h0, "R3 disabled source masked");
    @(negedge clk); lvl_a = 6'h03; idle(3);
    rd(2, 32'h1, "R3 status");
    @(negedge clk); lvl_a = 6'h07; idle(3);
    rd(2, 32'h5, "R3 second source");
    // R5 retrigger while high, none when low
    wr(10, 0); idle(2);
    @(negedge clk); lvl_a = 0; idle(2);
    wr(10, 0); idle(2);
    // R6 out-of-range vector while bank 0 high
    @(negedge clk); lvl_a = 6'h01; idle(2);
    wr(10, 4); wr(10, 32'h100); idle(2);

    // R10 bank 1 groups
    wr(3, 32'hffff_ffff); idle(1); rd(5, 32'h0, "R2 bank1 status idle");
    rd(3, 32'h07ff_ffff, "R2 bank1 mask");
    @(negedge clk); lvl_b = 27'h080_0000; idle(2);
    rd(5, 32'h0080_0000, "R3 bank1 legacy");
    wr(10, 2); wr(10, 1); wr(10, 3); idle(2);
    @(negedge clk); lvl_b = 27'h420_0000; idle(2);
    wr(10, 1); idle(2);
    wr(4, 32'h0400_0000); idle(1); rd(4, 32'h03ff_ffff, "R2 bank1 clear");
    wr(10, 3); idle(2);
    @(negedge clk); lvl_b = 0; idle(2);

    // R7 R8 R9 bank 2 pulses
    wr(6, 32'h0000_07c0); idle(1); rd(6, 32'h7c0, "R2 bank2 mask");
    pulse_c(12'h080, 0); idle(2); rd(8, 32'h080, "R7 sticky set");
    pulse_c(12'h080, 0); idle(2);
    pulse_c(12'h001, 0); idle(2); rd(8, 32'h081, "R7 disabled still latches");
    wr(9, 0); idle(1); rd(8, 32'h081, "R7 clear zero");
    wr(9, 32'h080); idle(1); rd(8, 32'h001, "R7 clear one");
    pulse_c(12'h400, 1); idle(2); rd(8, 32'h401, "R8 set wins");
    pulse_c(12'h600, 0); idle(2); rd(8, 32'h601, "R9 new bit");
    wr(9, 32'hfff); idle(1); rd(8, 32'h0, "R7 clear all");
    pulse_c(12'h800, 0); pulse_c(12'h100, 0); idle(3);
    rd(8, 32'h900, "R9 timer and error");

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule